// File: doc/BRIEF.md
# Low-Power Pending Event Latch

This block sits beside a processor core and holds on to side-band events that arrive while the core is parked in a clock-stopped grant state. The five side-band lines are a system-management request, an init request, a bus-init request and two local interrupt lines. They are asynchronous to the block clock. A sixth source is a single-cycle interrupt strobe delivered over the front side bus. None of these events is lost while the core is stopped. None is serviced either: each is recorded as pending.

When the power-state input returns to the running code, every pending event is handed to the core as a one-cycle service pulse. All pending events are delivered in the same cycle, and each event type is delivered once no matter how often it fired. While anything is pending, an active-low break-event output asks system logic to bring the core back to normal operation. The interrupt-enable flag does not mask this output. In the running state, events bypass the latch and are turned straight into service pulses.

Top module: `lp_event_latch`

## Requirements
- R1: Each side-band line passes through a two-flop synchroniser followed by a rising-edge detector. A level held high for any number of cycles counts as one occurrence. A line that goes high before clock edge k gives its occurrence in the cycle after edge k+1.
- R2: When `pwr_state_i` is 2'b00 (running), an occurrence of event i is registered into `svc_o[i]` at the next edge and lasts exactly one cycle. The bit order of `svc_o` is 0 system management, 1 init, 2 bus init, 3 local interrupt 0, 4 local interrupt 1, 5 bus interrupt. `evt_i` uses the same order for bits 0 to 4.
- R3: When `pwr_state_i` is 2'b01 (grant), 2'b10 (grant snoop) or 2'b11 (treated as grant), occurrences set pending flags and `svc_o` stays all zero.
- R4: A bus interrupt strobe (`bus_irq_i` high at a clock edge) is one occurrence of event 5. It is not synchronised and is captured in the stopped states in the same way as the side-band events.
- R5: At the first edge where `pwr_state_i` reads running, every pending flag produces its pulse in the following cycle and all pending flags clear at that same edge.
- R6: Any number of occurrences of one event type while stopped yield exactly one pulse on that type's bit at return. A pending flag stays set for as long as the state is stopped.
- R7: `brk_n_o` is low in every cycle in which at least one pending flag is set, and high otherwise. It therefore goes high in the same cycle as the delivery pulses.
- R8: `irq_en_i` has no effect on `brk_n_o` or on `svc_o`. A masked interrupt still drives `brk_n_o` low.
- R9: A synchronous active-high `rst` clears the synchronisers, the pending flags and `svc_o`, and drives `brk_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 5 | Asynchronous side-band event lines |
| bus_irq_i | input | 1 | Bus-delivered interrupt strobe, synchronous |
| irq_en_i | input | 1 | Core interrupt-enable flag (does not mask the wake request) |
| pwr_state_i | input | 2 | Power state: 00 running, 01 grant, 10 grant snoop, 11 treated as stopped |
| svc_o | output | 6 | One-cycle service pulse for each event type |
| brk_n_o | output | 1 | Active-low break-event request to system logic |

## Verification
The bench holds a side-band line high for many cycles. A design that sampled levels instead of edges would emit a pulse train, or re-latch the event after delivery.

The bench fires the same event several times across both stopped codes, then checks that return gives exactly one pulse per type, with all types in one cycle. A design that queued occurrences, or delivered them one after another, would show extra or staggered pulses.

With the interrupt-enable flag clear, the bench still expects the break-event output low. This catches a design that gates the wake request with the mask.

The bench also switches state on the same cycle an occurrence appears. This catches an event that is dropped, or delivered twice, at the state boundary.

// File: rtl/lp_evt_pkg.sv
package lp_evt_pkg;

  localparam int unsigned SB_LINES_DEF = 5;
  localparam int unsigned SYNC_DEF     = 2;

  typedef enum logic [1:0] {
    PST_RUN   = 2'b00,
    PST_GRANT = 2'b01,
    PST_SNOOP = 2'b10,
    PST_RSVD  = 2'b11
  } pwr_state_e;

  // Only the running code releases events; every other code holds them.
  function automatic logic is_running(input logic [1:0] st);
    return (st == PST_RUN);
  endfunction

  // Rising edge of a synchronised level: current stage high, previous low.
  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/lp_sync_edge.sv
module lp_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  import lp_evt_pkg::*;

  localparam int unsigned CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], async_i};
  end

  assign rise_o = edge_up(chain_q[STAGES-1], chain_q[STAGES]);

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R1

endmodule

// File: rtl/lp_pend_store.sv
module lp_pend_store #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [WIDTH-1:0] occ_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] svc_o
);

  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] svc_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[g] <= 1'b0;
        svc_q[g]  <= 1'b0;
      end else if (run_i) begin
        svc_q[g]  <= pend_q[g] | occ_i[g];
        pend_q[g] <= 1'b0;
      end else begin
        svc_q[g]  <= 1'b0;
        pend_q[g] <= pend_q[g] | occ_i[g];
      end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
      (pend_q[g] && !run_i) |=> pend_q[g]); // R6
  end

  assign pend_o = pend_q;
  assign svc_o  = svc_q;

  AST_NO_PULSE_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (svc_q == '0)); // R3

endmodule

// File: rtl/lp_brk_gen.sv
module lp_brk_gen #(
  parameter int unsigned WIDTH = 6
) (
  input  logic [WIDTH-1:0] pend_i,
  output logic             brk_n_o
);
  // Wake request is the plain OR of pending flags; no enable term enters here.
  assign brk_n_o = ~(|pend_i);
endmodule

// File: rtl/lp_event_latch.sv
module lp_event_latch #(
  parameter int unsigned SB_LINES = lp_evt_pkg::SB_LINES_DEF,
  parameter int unsigned SYNC_STG = lp_evt_pkg::SYNC_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SB_LINES-1:0] evt_i,
  input  logic                bus_irq_i,
  input  logic                irq_en_i,
  input  logic [1:0]          pwr_state_i,
  output logic [SB_LINES:0]   svc_o,
  output logic                brk_n_o
);
  import lp_evt_pkg::*;

  localparam int unsigned N_EV = SB_LINES + 1;

  logic [SB_LINES-1:0] sb_rise;
  logic [N_EV-1:0]     occ;
  logic [N_EV-1:0]     pend;
  logic                run;

  for (genvar g = 0; g < SB_LINES; g++) begin : g_sync
    lp_sync_edge #(.STAGES(SYNC_STG)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (evt_i[g]),
      .rise_o  (sb_rise[g])
    );
  end

  assign run = is_running(pwr_state_i);
  assign occ = {bus_irq_i, sb_rise};

  lp_pend_store #(.WIDTH(N_EV)) u_store (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .occ_i  (occ),
    .pend_o (pend),
    .svc_o  (svc_o)
  );

  lp_brk_gen #(.WIDTH(N_EV)) u_brk (
    .pend_i  (pend),
    .brk_n_o (brk_n_o)
  );

  AST_WAKE_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!run && (occ != '0)) |=> !brk_n_o); // R7

  AST_MASK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (!run && bus_irq_i && !irq_en_i) |=> !brk_n_o); // R8

  AST_RETURN_DELIVERS: assert property (@(posedge clk) disable iff (rst)
    (run && !brk_n_o) |=> (brk_n_o && (svc_o != '0))); // R5

  AST_BUS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!run && bus_irq_i) |=> (pend[SB_LINES] && svc_o[SB_LINES] == 1'b0)); // R4

endmodule

// File: tb/lp_event_latch_tb_top.sv
module lp_event_latch_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] evt = '0;
  logic       bus_irq = 1'b0;
  logic       irq_en = 1'b1;
  logic [1:0] pst = 2'b00;
  logic [5:0] svc;
  logic       brk_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R9";

  // reference model state
  logic [4:0] h0 = '0, h1 = '0, h2 = '0;
  logic [5:0] m_pend = '0;
  logic [5:0] m_svc = '0;
  logic       m_brk = 1'b1;
  int         pulse_cnt [6];

  always #2 clk = ~clk;

  lp_event_latch dut_i (
    .clk(clk), .rst(rst), .evt_i(evt), .bus_irq_i(bus_irq),
    .irq_en_i(irq_en), .pwr_state_i(pst), .svc_o(svc), .brk_n_o(brk_n)
  );

  always @(posedge clk) begin
    logic [5:0] occ;
    if (rst) begin
      h0 = '0; h1 = '0; h2 = '0;
      m_pend = '0; m_svc = '0;
    end else begin
      occ = {bus_irq, h1 & ~h2};
      h2 = h1; h1 = h0; h0 = evt;
      if (pst == 2'b00) begin
        m_svc = m_pend | occ;
        m_pend = '0;
      end else begin
        m_svc = '0;
        m_pend = m_pend | occ;
      end
    end
    m_brk = (m_pend == '0);
    cycles++;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      check(cur_req, svc, m_svc, "svc_o vs model");
      check("R7", brk_n, m_brk, "brk_n_o vs model");
      for (int i = 0; i < 6; i++) if (svc[i]) pulse_cnt[i]++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_cnt();
    for (int i = 0; i < 6; i++) pulse_cnt[i] = 0;
  endtask

  initial begin
    clr_cnt();
    tick(3);
    check("R9", svc, 0, "reset svc");
    check("R9", brk_n, 1, "reset brk_n");
    rst = 1'b0;

    // R2 / R1: pulse and held level while running
    cur_req = "R2";
    tick(2); clr_cnt();
    evt[0] = 1'b1; tick(12);
    check("R1", pulse_cnt[0], 1, "held level pulse count");
    evt[0] = 1'b0; tick(4);
    clr_cnt();
    bus_irq = 1'b1; tick(1); bus_irq = 1'b0; tick(2);
    check("R2", pulse_cnt[5], 1, "bus irq pass-through");

    // R3 / R4 / R6 / R8: capture in grant and snoop codes, masked
    cur_req = "R3";
    irq_en = 1'b0;
    pst = 2'b01; clr_cnt();
    bus_irq = 1'b1; tick(1); bus_irq = 1'b0; tick(1);
    check("R8", brk_n, 0, "masked irq wakes");
    for (int k = 0; k < 3; k++) begin
      evt = 5'b11011; tick(2); evt = '0; tick(3);
      bus_irq = 1'b1; tick(1); bus_irq = 1'b0;
    end
    pst = 2'b10;
    evt[2] = 1'b1; tick(3); evt[2] = 1'b0; tick(5);
    pst = 2'b11; tick(3);
    check("R3", pulse_cnt[0] + pulse_cnt[2] + pulse_cnt[5], 0, "no pulse stopped");
    check("R4", brk_n, 0, "pending holds wake");

    // R5 / R6: return delivers once, together
    cur_req = "R5";
    pst = 2'b00; tick(1);
    check("R5", svc, 6'h3f, "all delivered together");
    check("R7", brk_n, 1, "wake released with pulses");
    tick(6);
    for (int i = 0; i < 6; i++) check("R6", pulse_cnt[i], 1, "single delivery per type");
    irq_en = 1'b1;

    // boundary: occurrence on the switching cycles, then random mix
    cur_req = "R6";
    pst = 2'b01; bus_irq = 1'b1; tick(1); bus_irq = 1'b0; pst = 2'b00;
    tick(1);
    check("R5", svc[5], 1, "boundary capture delivered");
    cur_req = "R2";
    for (int c = 0; c < 3000; c++) begin
      if (($urandom % 8) == 0) pst = 2'($urandom);
      if (($urandom % 5) == 0) evt = 5'($urandom);
      bus_irq = (($urandom % 7) == 0);
      irq_en = 1'($urandom);
      tick(1);
    end
    rst = 1'b1; tick(1);
    check("R9", brk_n, 1, "reset mid-run brk_n");
    check("R9", svc, 0, "reset mid-run svc");
    rst = 1'b0; tick(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule